// File: doc/BRIEF.md
# Addend-Tuned Precision Time Counter

This block keeps a 64-bit time of day counted in ticks of 32 ns, so a nanosecond value is the tick count shifted left by five. A fractional rate accumulator adds a programmable increment every clock. Each carry out of the accumulator moves the time forward by one tick. Software trims the clock frequency by changing that increment alone. The default increment of 0xA000_0000 yields ten ticks in every sixteen clocks.

Software reaches the block through a simple 32-bit register port. The time is split into a low and a high word. A write to the low word is held back until the high word is written, so both words change on the same edge. A read of the low word freezes the matching high word for a later read. Software can also program a compare time and a ceiling for the low word. The block drives the live time and a one-cycle pulse when the time first reaches the compare time.

Top module: `ptp_tick_clock`

## Requirements
- R1: After reset the time is 0, the increment is 0xA000_0000, the compare time is high 0 / low 1, the low-word ceiling is disabled with value 0, and the pending flag is 0.
- R2: Each clock the accumulator and the increment are summed at 33 bits. The lower 32 bits are kept and bit 32 advances the time by exactly one tick. With the default increment and a freshly cleared accumulator, 16 clocks give exactly 10 ticks.
- R3: A new increment governs the sum from the clock after its write. An increment of 0 freezes the time. 0xFFFF_FFFF from a cleared accumulator gives 15 ticks in 16 clocks.
- R4: A write to address 1 only stages the low word and leaves the time unchanged. A write to address 2 loads the high word with the written data and the low word with the staged value on one edge, and clears the accumulator.
- R5: A read of address 1 returns the live low word and captures the live high word into a shadow. A read of address 2 returns that shadow, even if the time has since carried into the high word.
- R6: While the ceiling enable (address 5, bit 0) is 1, a tick with the low word at or above the ceiling (address 6) sets the low word to 0 and increments the high word. While the enable is 0, the ceiling has no effect and the low word wraps only past 0xFFFF_FFFF.
- R7: The compare-hit output is high for one clock, on the first clock where the time is greater than or equal to the compare time (address 4 high, address 3 low). That hit sets a pending flag, read at address 7 bit 0. Writing 1 to address 7 bit 0 clears the flag, but a hit in the same clock wins.
- R8: Register map, read and write unless noted: 0 increment; 1 time low (writing stages it); 2 time high; 3 compare low; 4 compare high; 5 ceiling enable in bit 0; 6 ceiling; 7 pending flag in bit 0, write 1 to clear. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has side effect on address 1) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| time_now | output | 64 | Current time in ticks, high word above low word |
| target_hit | output | 1 | One-clock pulse when the time first reaches the compare time |

## Verification
The bound checker checks on every clock that, without a high-word load, the time either holds, steps by one tick or wraps its low word into a high-word increment. It also checks that a high-word write lands on the next edge, that a zero increment freezes the time, that a low read fills the shadow, and that the hit output never lasts two clocks and always leaves the flag pending. Only the bench scenarios show exact tick counts for a given increment, the ceiling wrap point with the enable on and off, the staged low word, the frozen high word seen after a carry, and that exactly one hit occurs across a crossing.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_RATE    = 3'd0,
      RA_TLO     = 3'd1,
      RA_THI     = 3'd2,
      RA_CMP_LO  = 3'd3,
      RA_CMP_HI  = 3'd4,
      RA_CEIL_EN = 3'd5,
      RA_CEIL    = 3'd6,
      RA_FLAG    = 3'd7
   } ptc_reg_e;
endpackage

// File: rtl/ptc_rate_accum.sv
module ptc_rate_accum #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [ACC_W-1:0] rate,
   output logic             tick
);
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   sum;

   assign sum  = {1'b0, acc_q} + {1'b0, rate};
   assign tick = sum[ACC_W] & ~clear;

   always_ff @(posedge clk) begin
      if (!rst_n)      acc_q <= '0;
      else if (clear)  acc_q <= '0;
      else             acc_q <= sum[ACC_W-1:0];
   end
endmodule

// File: rtl/ptc_time_core.sv
module ptc_time_core #(
   parameter int WORD_W    = 32,
   parameter bit HAS_CEIL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [WORD_W-1:0] load_lo,
   input  logic [WORD_W-1:0] load_hi,
   input  logic              ceil_en,
   input  logic [WORD_W-1:0] ceil_val,
   output logic [WORD_W-1:0] lo,
   output logic [WORD_W-1:0] hi
);
   logic [WORD_W-1:0] limit;

   generate
      if (HAS_CEIL) begin : g_ceil
         assign limit = ceil_en ? ceil_val : '1;
      end else begin : g_noceil
         logic unused_ok;
         assign unused_ok = ceil_en ^ (^ceil_val);
         assign limit = '1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo <= '0;
         hi <= '0;
      end else if (load) begin
         lo <= load_lo;
         hi <= load_hi;
      end else if (tick) begin
         if (lo >= limit) begin
            lo <= '0;
            hi <= hi + WORD_W'(1);
         end else begin
            lo <= lo + WORD_W'(1);
         end
      end
   end
endmodule

// File: rtl/ptc_target_cmp.sv
module ptc_target_cmp #(
   parameter int TIME_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now,
   input  logic [TIME_W-1:0] target,
   output logic              hit
);
   logic reached;
   logic reached_q;

   assign reached = (now >= target);
   assign hit     = reached & ~reached_q;

   always_ff @(posedge clk) begin
      if (!rst_n) reached_q <= 1'b0;
      else        reached_q <= reached;
   end
endmodule

// File: rtl/ptp_tick_clock.sv
module ptp_tick_clock
   import ptc_pkg::*;
#(
   parameter int                WORD_W     = 32,
   parameter int                ACC_W      = 32,
   parameter logic [ACC_W-1:0]  RATE_RST   = 'hA000_0000,
   parameter logic [WORD_W-1:0] CMP_LO_RST = 'd1,
   parameter bit                HAS_CEIL   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [63:0]       time_now,
   output logic              target_hit
);
   localparam int TIME_W = 2 * WORD_W;

   generate
      if (WORD_W != 32) begin : g_bad_word
         $error("ptp_tick_clock: WORD_W must match the 32-bit register port");
      end
      if (ACC_W > WORD_W || ACC_W < 4) begin : g_bad_acc
         $error("ptp_tick_clock: ACC_W must lie in 4..WORD_W");
      end
   endgenerate

   logic [ACC_W-1:0]  rate_q;
   logic [WORD_W-1:0] stage_lo_q, shadow_hi_q;
   logic [WORD_W-1:0] cmp_lo_q, cmp_hi_q, ceil_q;
   logic              ceil_en_q, flag_q;
   logic [WORD_W-1:0] t_lo, t_hi;
   logic              tick, load_time, hit;

   logic wr_rate, wr_tlo, wr_thi, wr_clo, wr_chi, wr_cen, wr_ceil, wr_flag, rd_tlo;
   assign wr_rate = reg_wr && (reg_addr == RA_RATE);
   assign wr_tlo  = reg_wr && (reg_addr == RA_TLO);
   assign wr_thi  = reg_wr && (reg_addr == RA_THI);
   assign wr_clo  = reg_wr && (reg_addr == RA_CMP_LO);
   assign wr_chi  = reg_wr && (reg_addr == RA_CMP_HI);
   assign wr_cen  = reg_wr && (reg_addr == RA_CEIL_EN);
   assign wr_ceil = reg_wr && (reg_addr == RA_CEIL);
   assign wr_flag = reg_wr && (reg_addr == RA_FLAG);
   assign rd_tlo  = reg_rd && (reg_addr == RA_TLO);
   assign load_time = wr_thi;

   ptc_rate_accum #(.ACC_W(ACC_W)) u_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (load_time),
      .rate  (rate_q),
      .tick  (tick)
   );

   ptc_time_core #(.WORD_W(WORD_W), .HAS_CEIL(HAS_CEIL)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (load_time),
      .load_lo  (stage_lo_q),
      .load_hi  (reg_wdata),
      .ceil_en  (ceil_en_q),
      .ceil_val (ceil_q),
      .lo       (t_lo),
      .hi       (t_hi)
   );

   ptc_target_cmp #(.TIME_W(TIME_W)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .now    ({t_hi, t_lo}),
      .target ({cmp_hi_q, cmp_lo_q}),
      .hit    (hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q      <= RATE_RST;
         stage_lo_q  <= '0;
         shadow_hi_q <= '0;
         cmp_lo_q    <= CMP_LO_RST;
         cmp_hi_q    <= '0;
         ceil_en_q   <= 1'b0;
         ceil_q      <= '0;
         flag_q      <= 1'b0;
      end else begin
         if (wr_rate) rate_q     <= reg_wdata[ACC_W-1:0];
         if (wr_tlo)  stage_lo_q <= reg_wdata;
         if (wr_clo)  cmp_lo_q   <= reg_wdata;
         if (wr_chi)  cmp_hi_q   <= reg_wdata;
         if (wr_cen)  ceil_en_q  <= reg_wdata[0];
         if (wr_ceil) ceil_q     <= reg_wdata;
         if (rd_tlo)  shadow_hi_q <= t_hi;
         if (hit)                         flag_q <= 1'b1;
         else if (wr_flag && reg_wdata[0]) flag_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (reg_addr)
         RA_RATE:    reg_rdata = WORD_W'(rate_q);
         RA_TLO:     reg_rdata = t_lo;
         RA_THI:     reg_rdata = shadow_hi_q;
         RA_CMP_LO:  reg_rdata = cmp_lo_q;
         RA_CMP_HI:  reg_rdata = cmp_hi_q;
         RA_CEIL_EN: reg_rdata = WORD_W'(ceil_en_q);
         RA_CEIL:    reg_rdata = ceil_q;
         RA_FLAG:    reg_rdata = WORD_W'(flag_q);
         default:    reg_rdata = '0;
      endcase
   end

   assign time_now   = {t_hi, t_lo};
   assign target_hit = hit;
endmodule

// File: rtl/ptp_tick_clock_chk.sv
module ptp_tick_clock_chk #(
   parameter int WORD_W = 32,
   parameter int ACC_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [2:0]        reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [63:0]       time_now,
   input logic              target_hit,
   input logic [ACC_W-1:0]  rate_q,
   input logic [WORD_W-1:0] shadow_hi_q,
   input logic              flag_q
);
   logic hi_wr, lo_rd;
   assign hi_wr = reg_wr && (reg_addr == 3'd2);
   assign lo_rd = reg_rd && (reg_addr == 3'd1);

   // R2: without a load the time holds, steps one tick, or wraps low into high
   p_time_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_wr |=> (time_now == $past(time_now)) ||
                 (time_now == $past(time_now) + 64'd1) ||
                 (time_now[31:0] == 32'd0 &&
                  time_now[63:32] == $past(time_now[63:32]) + 32'd1));

   // R3: a zero increment freezes the time
   p_zero_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_q == '0 && !hi_wr) |=> time_now == $past(time_now));

   // R4: a high-word write lands on the next edge
   p_hi_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hi_wr |=> time_now[63:32] == $past(reg_wdata));

   // R5: a low-word read captures the high word into the shadow
   p_shadow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lo_rd |=> shadow_hi_q == $past(time_now[63:32]));

   // R7: hit is a single-clock pulse
   p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      target_hit |=> !target_hit);

   // R7: a hit always leaves the flag pending
   p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      target_hit |=> flag_q);
endmodule

bind ptp_tick_clock ptp_tick_clock_chk #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr      (reg_wr),
   .reg_rd      (reg_rd),
   .reg_addr    (reg_addr),
   .reg_wdata   (reg_wdata),
   .time_now    (time_now),
   .target_hit  (target_hit),
   .rate_q      (rate_q),
   .shadow_hi_q (shadow_hi_q),
   .flag_q      (flag_q)
);

// File: tb/ptp_tick_clock_test.sv
module ptp_tick_clock_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        b_wr = 1'b0, b_rd = 1'b0;
   logic [2:0]  b_addr = '0;
   logic [31:0] b_wdata = '0;
   logic [31:0] rdata;
   logic [63:0] time_now;
   logic        target_hit;

   int tests = 0, fails = 0, hits = 0;
   bit cmp_on = 1'b0;

   always #5 clk = ~clk;

   ptp_tick_clock uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(b_wr), .reg_rd(b_rd),
      .reg_addr(b_addr), .reg_wdata(b_wdata), .reg_rdata(rdata),
      .time_now(time_now), .target_hit(target_hit)
   );

   // behavioural reference
   logic [31:0] m_acc, m_rate, m_lo, m_hi, m_stage, m_shadow, m_clo, m_chi, m_ceil;
   bit          m_cen, m_geq, m_flag;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = 0; m_rate = 32'hA000_0000; m_lo = 0; m_hi = 0; m_stage = 0;
         m_shadow = 0; m_clo = 1; m_chi = 0; m_ceil = 0; m_cen = 0;
         m_geq = 0; m_flag = 0;
      end else begin
         automatic logic [32:0] s   = {1'b0, m_acc} + {1'b0, m_rate};
         automatic logic [31:0] lim = m_cen ? m_ceil : 32'hFFFF_FFFF;
         automatic bit          ge  = {m_hi, m_lo} >= {m_chi, m_clo};
         automatic bit          pl  = ge && !m_geq;
         automatic logic [31:0] oh  = m_hi;
         if (b_wr && b_addr == 3'd2) begin
            m_hi = b_wdata; m_lo = m_stage; m_acc = 0;
         end else begin
            m_acc = s[31:0];
            if (s[32]) begin
               if (m_lo >= lim) begin m_lo = 0; m_hi = m_hi + 1; end
               else m_lo = m_lo + 1;
            end
         end
         m_geq = ge;
         if (pl) m_flag = 1;
         else if (b_wr && b_addr == 3'd7 && b_wdata[0]) m_flag = 0;
         if (b_rd && b_addr == 3'd1) m_shadow = oh;
         if (b_wr) begin
            case (b_addr)
               3'd0: m_rate  = b_wdata;
               3'd1: m_stage = b_wdata;
               3'd3: m_clo   = b_wdata;
               3'd4: m_chi   = b_wdata;
               3'd5: m_cen   = b_wdata[0];
               3'd6: m_ceil  = b_wdata;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return m_rate;
         3'd1: return m_lo;
         3'd2: return m_shadow;
         3'd3: return m_clo;
         3'd4: return m_chi;
         3'd5: return {31'd0, m_cen};
         3'd6: return m_ceil;
         default: return {31'd0, m_flag};
      endcase
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // every-clock comparison against the reference (R2 time, R7 pulse)
   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         chk("R2 time", time_now, {m_hi, m_lo});
         chk("R7 hit", {63'd0, target_hit},
             {63'd0, ({m_hi, m_lo} >= {m_chi, m_clo}) && !m_geq});
         if (target_hit) hits++;
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      b_wr = 1'b1; b_addr = a; b_wdata = d;
      @(negedge clk);
      b_wr = 1'b0;
   endtask

   task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
      b_rd = 1'b1; b_addr = a;
      #1;
      chk(req, {32'd0, rdata}, {32'd0, exp});
      @(negedge clk);
      b_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #2_000_000;
      fails++; tests++;
      $display("FAIL watchdog actual hung expected done");
      finish_run();
   end

   initial begin
      logic [63:0] t0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      // R1 reset state
      rd("R1 flag", 3'd7, 32'd0);
      chk("R1 time", time_now, 64'd0);
      rd("R1 rate", 3'd0, 32'hA000_0000);
      rd("R1 cmp lo", 3'd3, 32'd1);
      rd("R1 cmp hi", 3'd4, 32'd0);
      rd("R1 ceil en", 3'd5, 32'd0);
      rd("R8 ceil", 3'd6, 32'd0);

      // R2 default rate: 10 ticks in 16 clocks
      wr(3'd1, 32'd0);
      wr(3'd2, 32'h100);
      idle(16);
      chk("R2 ten ticks", time_now, {32'h100, 32'd10});
      // R7 pending flag set by the early hit, then cleared
      rd("R7 flag set", 3'd7, 32'd1);
      wr(3'd7, 32'd1);
      rd("R7 flag clear", 3'd7, 32'd0);

      // R3 zero rate freezes, full rate 15 of 16
      wr(3'd0, 32'd0);
      t0 = time_now;
      idle(10);
      chk("R3 frozen", time_now, t0);
      wr(3'd0, 32'hFFFF_FFFF);
      wr(3'd2, 32'h200);
      t0 = {32'h200, m_lo};
      idle(16);
      chk("R3 fifteen ticks", time_now, t0 + 64'd15);

      // R4 staged low word
      wr(3'd0, 32'd0);
      t0 = time_now;
      wr(3'd1, 32'hFFFF_FFF0);
      chk("R4 staged only", time_now, t0);
      wr(3'd2, 32'd5);
      chk("R4 both words", time_now, {32'd5, 32'hFFFF_FFF0});
      wr(3'd0, 32'hFFFF_FFFF);
      idle(40);
      chk("R6 full wrap", {32'd0, time_now[63:32]}, 64'd6);

      // R6 ceiling enabled
      wr(3'd5, 32'd1);
      wr(3'd6, 32'h20);
      rd("R8 ceil rd", 3'd6, 32'h20);
      wr(3'd1, 32'h1C);
      wr(3'd2, 32'd2);
      idle(12);
      chk("R6 ceiling wrap", time_now, {32'd3, 32'd6});
      wr(3'd5, 32'd0);
      wr(3'd1, 32'h1C);
      wr(3'd2, 32'd4);
      idle(12);
      chk("R6 ceiling off", time_now, {32'd4, 32'h27});

      // R5 coherent read across a carry
      wr(3'd1, 32'hFFFF_FFF8);
      wr(3'd2, 32'd9);
      rd("R5 low read", 3'd1, m_lo);
      idle(20);
      chk("R5 carried", {32'd0, time_now[63:32]}, 64'd10);
      rd("R5 shadow hi", 3'd2, 32'd9);

      // R7 single hit across a crossing
      wr(3'd0, 32'd0);
      wr(3'd3, 32'd10);
      wr(3'd4, 32'd70);
      wr(3'd1, 32'd0);
      wr(3'd2, 32'd70);
      wr(3'd7, 32'd1);
      rd("R7 flag idle", 3'd7, 32'd0);
      hits = 0;
      wr(3'd0, 32'hFFFF_FFFF);
      idle(40);
      chk("R7 one pulse", 64'(hits), 64'd1);
      rd("R7 flag after", 3'd7, 32'd1);
      rd("R8 rate rd", 3'd0, m_read(3'd0));
      finish_run();
   end
endmodule